// File: doc/BRIEF.md
# Multi-Slice Line-Change Timestamp Engine

This block watches a wide bundle of input lines, split into groups of 32 called slices. Each slice has a per-line enable mask. When the masked value of a slice differs from the value last recorded for it, the block captures an event. The event holds the value of a free-running 64-bit tick counter at the moment of detection, the slice number, and the slice's old and new masked values. Software finds which lines moved by XOR-ing the old and new values, so lines in one slice that move together share one event.

Events go into a queue of parameterised depth. Software reads the head event through a small 32-bit register port and releases it with a command write. A level interrupt tells software that the queue has filled to a programmed threshold. The number of slices and the queue depth are parameters. The tick counter runs inside the block and counts clock cycles from reset.

Top module: `edge_stamp_engine`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0x0000_0100, meaning run off, interrupt off and threshold 1. Status (0x20) reads 0, the head registers read 0, and `irq_o` is low.
- R2: With run on (control bit 0), a change of an enabled line queues one entry. The head source register (0x0C) carries the slice index in bits [23:16] and zero elsewhere. The new masked value is at 0x10 and the old masked value is at 0x14.
- R3: Lines whose enable bit is 0 are seen as 0, so toggling them queues nothing.
- R4: Several enabled lines of one slice that change in the same cycle produce a single entry, and its old/new XOR marks every one of them.
- R5: When several slices detect a change in the same cycle, their entries are queued on consecutive cycles in ascending slice order. All of them carry the same timestamp.
- R6: The head timestamp reads as the upper word at 0x04 and the lower word at 0x08. It counts clock cycles, so two changes applied N cycles apart give timestamps that differ by N.
- R7: Status bits [15:8] give the number of queued entries.
- R8: Writing 1 to bit 0 of the command register (0x1C) removes the head entry. On an empty queue this write has no effect, and the head registers read 0.
- R9: An event that arrives while the queue holds FIFO_DEPTH entries is dropped, and it sets the sticky overflow flag in status bit 0. Writing 1 to that bit clears the flag and leaves the occupancy unchanged.
- R10: `irq_o` is high exactly when run is on, interrupt enable (control bit 1) is on, and the occupancy is at least the threshold in control bits [15:8]. It falls once pops bring the occupancy below the threshold.
- R11: While run is off, no entries are queued. The recorded value follows the lines, so a change made while stopped is not reported after run is turned back on.
- R12: Slice s has a read/write 32-bit line-enable register at 0x40 + 0x20·s, one bit per line. Line number = 32·s + bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_in | input | 32·NUM_SLICES | Asynchronous watched lines, line k at bit k |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Level interrupt on occupancy threshold |

## Verification
A stale recorded value in a slice shows up as a missing entry or a spurious one, about four cycles after the lines move. The entry appears as a jump in the status occupancy and in the old/new pair at the head. A wrong arbitration order or a timestamp captured at the wrong time shows up when two queued entries are read back: their slice fields come out in the wrong order, or their timestamps differ by something other than the spacing applied to the inputs. A bad queue count is visible at once in status bits [15:8] and in `irq_o`, on the cycle after a push or pop.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

    localparam int SLICE_W = 32;
    localparam int TS_W    = 64;

    localparam int OFS_CTRL    = 'h00;
    localparam int OFS_TS_HI   = 'h04;
    localparam int OFS_TS_LO   = 'h08;
    localparam int OFS_SRC     = 'h0C;
    localparam int OFS_CUR     = 'h10;
    localparam int OFS_PREV    = 'h14;
    localparam int OFS_CMD     = 'h1C;
    localparam int OFS_STAT    = 'h20;
    localparam int OFS_EN_BASE = 'h40;
    localparam int EN_STRIDE   = 'h20;

    typedef struct packed {
        logic [TS_W-1:0]    ts;
        logic [7:0]         slice;
        logic [SLICE_W-1:0] cur;
        logic [SLICE_W-1:0] prev;
    } stamp_entry_t;

    typedef struct packed {
        logic [7:0] thresh;
        logic       irq_en;
        logic       run;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{thresh: 8'd1, irq_en: 1'b0, run: 1'b0};

    function automatic logic [31:0] ctrl_to_word(ctrl_t c);
        return {16'h0, c.thresh, 6'h0, c.irq_en, c.run};
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [31:0] w);
        ctrl_t c;
        c.thresh = w[15:8];
        c.irq_en = w[1];
        c.run    = w[0];
        return c;
    endfunction

endpackage

// File: rtl/es_slice_watch.sv
module es_slice_watch
    import edge_stamp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SLICE_W-1:0] raw,
    input  logic [SLICE_W-1:0] mask,
    input  logic               run,
    input  logic [TS_W-1:0]    ts_now,
    input  logic               grant,
    output logic               pend,
    output logic [TS_W-1:0]    pend_ts,
    output logic [SLICE_W-1:0] pend_cur,
    output logic [SLICE_W-1:0] pend_prev
);
    logic [SLICE_W-1:0] sync1_q, sync2_q, seen_q, masked;

    assign masked = sync2_q & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q   <= '0;
            sync2_q   <= '0;
            seen_q    <= '0;
            pend      <= 1'b0;
            pend_ts   <= '0;
            pend_cur  <= '0;
            pend_prev <= '0;
        end else begin
            sync1_q <= raw;
            sync2_q <= sync1_q;
            if (!run) begin
                seen_q <= masked;
                pend   <= 1'b0;
            end else begin
                if (pend && grant)
                    pend <= 1'b0;
                if (!pend && masked != seen_q) begin
                    pend      <= 1'b1;
                    pend_ts   <= ts_now;
                    pend_cur  <= masked;
                    pend_prev <= seen_q;
                    seen_q    <= masked;
                end
            end
        end
    end

    // R5: a waiting event keeps its captured timestamp until it is granted
    a_r5_pend_hold: assert property (@(posedge clk) disable iff (rst)
        (pend && !grant && run) |=> (pend && $stable(pend_ts)));

    // R2: every new event records a real difference
    a_r2_real_change: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> (pend_cur != pend_prev));

endmodule

// File: rtl/es_pick_lowest.sv
module es_pick_lowest #(
    parameter int N = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end

    // R5: at most one slice is granted, and only a requesting one
    always_comb begin
        a_r5_grant_valid: assert (((grant & ~req) == '0) && $onehot0(grant));
    end

endmodule

// File: rtl/es_event_fifo.sv
module es_event_fifo
    import edge_stamp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  stamp_entry_t push_data,
    input  logic         pop,
    output stamp_entry_t head,
    output logic [CNT_W-1:0] count,
    output logic         full
);
    stamp_entry_t mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && (count != '0);
    assign head    = (count != '0) ? mem[rd_ptr] : '0;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop_ok)
                rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)
                count <= count + 1'b1;
            else if (pop_ok && !push_ok)
                count <= count - 1'b1;
        end
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    a_r8_pop_empty: assert property (@(posedge clk) disable iff (rst)
        (pop && count == '0 && !push) |=> (count == '0));

    a_r8_pop_one: assert property (@(posedge clk) disable iff (rst)
        (pop && count != '0 && !push) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/edge_stamp_engine.sv
module edge_stamp_engine
    import edge_stamp_pkg::*;
#(
    parameter int NUM_SLICES = 2,
    parameter int FIFO_DEPTH = 16,   // at most 255, to fit the occupancy field
    parameter int ADDR_W     = 12,
    localparam int LINES     = NUM_SLICES * SLICE_W,
    localparam int IDX_W     = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  lines_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_o
);
    ctrl_t              ctrl_q;
    logic [SLICE_W-1:0] en_q [NUM_SLICES];
    logic               ovf_q;
    logic [TS_W-1:0]    tick_q;

    logic [NUM_SLICES-1:0] pend, grant;
    logic [TS_W-1:0]       p_ts   [NUM_SLICES];
    logic [SLICE_W-1:0]    p_cur  [NUM_SLICES];
    logic [SLICE_W-1:0]    p_prev [NUM_SLICES];
    logic [IDX_W-1:0]      pick;
    logic                  push;

    stamp_entry_t      entry_in, head;
    logic [CNT_W-1:0]  count;
    logic              full, pop_cmd;
    logic [7:0]        occ;

    assign pop_cmd = reg_wr && (reg_addr == ADDR_W'(OFS_CMD)) && reg_wdata[0];
    assign occ     = 8'(count);

    // free-running tick counter
    always_ff @(posedge clk) begin
        if (rst) tick_q <= '0;
        else     tick_q <= tick_q + 1'b1;
    end

    // control, enables, overflow flag
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            ovf_q  <= 1'b0;
            for (int s = 0; s < NUM_SLICES; s++) en_q[s] <= '0;
        end else begin
            if (reg_wr && reg_addr == ADDR_W'(OFS_CTRL))
                ctrl_q <= word_to_ctrl(reg_wdata);
            for (int s = 0; s < NUM_SLICES; s++)
                if (reg_wr && reg_addr == ADDR_W'(OFS_EN_BASE + s * EN_STRIDE))
                    en_q[s] <= reg_wdata;
            if (push && full)
                ovf_q <= 1'b1;
            else if (reg_wr && reg_addr == ADDR_W'(OFS_STAT) && reg_wdata[0])
                ovf_q <= 1'b0;
        end
    end

    generate
        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
            es_slice_watch u_watch (
                .clk       (clk),
                .rst       (rst),
                .raw       (lines_in[s*SLICE_W +: SLICE_W]),
                .mask      (en_q[s]),
                .run       (ctrl_q.run),
                .ts_now    (tick_q),
                .grant     (grant[s]),
                .pend      (pend[s]),
                .pend_ts   (p_ts[s]),
                .pend_cur  (p_cur[s]),
                .pend_prev (p_prev[s])
            );
        end
    endgenerate

    es_pick_lowest #(.N(NUM_SLICES)) u_pick (
        .req   (pend),
        .grant (grant),
        .idx   (pick),
        .any   (push)
    );

    always_comb begin
        entry_in.ts    = p_ts[pick];
        entry_in.slice = 8'(pick);
        entry_in.cur   = p_cur[pick];
        entry_in.prev  = p_prev[pick];
    end

    es_event_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (entry_in),
        .pop       (pop_cmd),
        .head      (head),
        .count     (count),
        .full      (full)
    );

    assign irq_o = ctrl_q.run && ctrl_q.irq_en && (occ >= ctrl_q.thresh);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_CTRL):  reg_rdata = ctrl_to_word(ctrl_q);
            ADDR_W'(OFS_TS_HI): reg_rdata = head.ts[63:32];
            ADDR_W'(OFS_TS_LO): reg_rdata = head.ts[31:0];
            ADDR_W'(OFS_SRC):   reg_rdata = {8'h0, head.slice, 16'h0};
            ADDR_W'(OFS_CUR):   reg_rdata = head.cur;
            ADDR_W'(OFS_PREV):  reg_rdata = head.prev;
            ADDR_W'(OFS_STAT):  reg_rdata = {16'h0, occ, 7'h0, ovf_q};
            default:            reg_rdata = '0;
        endcase
        for (int s = 0; s < NUM_SLICES; s++)
            if (reg_addr == ADDR_W'(OFS_EN_BASE + s * EN_STRIDE))
                reg_rdata = en_q[s];
    end

    // R9: the overflow flag stays set until software clears it
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(reg_wr && reg_addr == ADDR_W'(OFS_STAT) && reg_wdata[0]))
        |=> ovf_q);

    // R11: a stopped engine has no event waiting one cycle after it stops
    a_r11_idle_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !$past(ctrl_q.run)) |-> (pend == '0));

    // R10: the interrupt falls after a pop that takes occupancy below the threshold
    a_r10_irq_drop: assert property (@(posedge clk) disable iff (rst)
        (irq_o && pop_cmd && !push && occ == ctrl_q.thresh
         && !(reg_wr && reg_addr == ADDR_W'(OFS_CTRL))) |=> !irq_o);

endmodule

// File: tb/edge_stamp_engine_tb.sv
module edge_stamp_engine_tb;
    localparam int NS = 2;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NS*32-1:0] lines = '0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    edge_stamp_engine #(.NUM_SLICES(NS), .FIFO_DEPTH(DEPTH), .ADDR_W(12)) u_dut (
        .clk(clk), .rst(rst), .lines_in(lines), .reg_addr(addr),
        .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(int a, logic [31:0] d);
        @(negedge clk);
        addr = 12'(a); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd_reg(int a, output logic [31:0] d);
        @(negedge clk);
        addr = 12'(a);
        #1 d = rdata;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(int k, logic v);
        @(negedge clk);
        lines[k] = v;
    endtask

    task automatic pop();
        wr_reg('h1C, 32'h1);
    endtask

    function automatic logic [31:0] occ_word(int n);
        return 32'(n) << 8;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd_reg('h00, d); chk("R1 ctrl", d, 32'h100);
        rd_reg('h20, d); chk("R1 status", d, 0);
        rd_reg('h0C, d); chk("R1 src", d, 0);
        rd_reg('h10, d); chk("R1 cur", d, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_enables();
        logic [31:0] d;
        wr_reg('h40, 32'hFFFF_FFFF);
        wr_reg('h60, 32'h0000_00FF);
        rd_reg('h40, d); chk("R12 en slice0", d, 32'hFFFF_FFFF);
        rd_reg('h60, d); chk("R12 en slice1", d, 32'h0000_00FF);
        wr_reg('h00, 32'h101);
    endtask

    task automatic t_single();
        logic [31:0] d;
        set_line(3, 1'b1); settle(6);
        rd_reg('h20, d); chk("R7 occupancy one", d, occ_word(1));
        rd_reg('h0C, d); chk("R2 src slice0", d, 0);
        rd_reg('h10, d); chk("R2 cur", d, 32'h8);
        rd_reg('h14, d); chk("R2 prev", d, 0);
        pop();
        rd_reg('h20, d); chk("R8 pop to empty", d, 0);
    endtask

    task automatic t_masked();
        logic [31:0] d;
        set_line(32 + 20, 1'b1); settle(6);
        rd_reg('h20, d); chk("R3 masked line ignored", d, 0);
    endtask

    task automatic t_multi();
        logic [31:0] c, p, d;
        @(negedge clk); lines[3] = 1'b0; lines[5] = 1'b1;
        settle(6);
        rd_reg('h20, d); chk("R4 one entry", d, occ_word(1));
        rd_reg('h10, c); rd_reg('h14, p);
        chk("R4 xor marks both", c ^ p, 32'h28);
        chk("R4 cur", c, 32'h20);
        pop();
    endtask

    task automatic t_two_slices();
        logic [31:0] d, lo0, hi0, lo1;
        @(negedge clk); lines[0] = 1'b1; lines[32 + 1] = 1'b1;
        settle(6);
        rd_reg('h20, d); chk("R5 two entries", d, occ_word(2));
        rd_reg('h0C, d); chk("R5 first slice0", d, 0);
        rd_reg('h08, lo0); rd_reg('h04, hi0);
        pop();
        rd_reg('h0C, d); chk("R5 second slice1", d, 32'h0001_0000);
        rd_reg('h10, d); chk("R5 slice1 cur masked", d, 32'h2);
        rd_reg('h08, lo1);
        chk("R5 same timestamp", lo1, lo0);
        chk("R6 high word small", hi0, 0);
        pop();
    endtask

    task automatic t_spacing();
        logic [31:0] a, b;
        set_line(7, 1'b1);
        settle(9);
        set_line(7, 1'b0);
        settle(6);
        rd_reg('h08, a); pop();
        rd_reg('h08, b); pop();
        chk("R6 tick spacing", b - a, 32'd10);
    endtask

    task automatic t_pop_empty();
        logic [31:0] d;
        pop();
        rd_reg('h20, d); chk("R8 pop on empty", d, 0);
        rd_reg('h10, d); chk("R8 empty head reads zero", d, 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr_reg('h00, 32'h203);
        set_line(8, 1'b1); settle(6);
        chk("R10 below threshold", irq, 0);
        set_line(8, 1'b0); settle(6);
        chk("R10 at threshold", irq, 1);
        pop(); settle(1);
        chk("R10 falls after pop", irq, 0);
        pop();
        rd_reg('h20, d); chk("R10 drained", d, 0);
        wr_reg('h00, 32'h101);
    endtask

    task automatic t_stopped();
        logic [31:0] d;
        wr_reg('h00, 32'h0);
        set_line(9, 1'b1); settle(6);
        rd_reg('h20, d); chk("R11 nothing while stopped", d, 0);
        wr_reg('h00, 32'h101); settle(6);
        rd_reg('h20, d); chk("R11 no stale report", d, 0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        for (int i = 0; i < DEPTH + 1; i++) begin
            set_line(10, ~lines[10]);
            settle(5);
        end
        rd_reg('h20, d); chk("R9 full plus flag", d, occ_word(DEPTH) | 32'h1);
        wr_reg('h20, 32'h1);
        rd_reg('h20, d); chk("R9 flag cleared", d, occ_word(DEPTH));
        for (int i = 0; i < DEPTH; i++) pop();
        rd_reg('h20, d); chk("R9 drained", d, 0);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle(2);
        t_reset();
        t_enables();
        t_single();
        t_masked();
        t_multi();
        t_two_slices();
        t_spacing();
        t_pop_empty();
        t_irq();
        t_stopped();
        t_overflow();
        done = 1'b1;
        report();
    end

endmodule